// File: doc/BRIEF.md
# Instrument Status Register Block

This block keeps the status state of a programmable instrument. It holds three status groups: operation, questionable and standard-event. Each group has a condition register that samples a raw condition vector every cycle. It also has an event register, which latches any condition bit that goes from 0 to 1, and an enable mask chosen by software. Each group reduces its masked events to one summary bit.

The three summaries, a message-available input and a service-request bit together form an 8-bit status byte. The service-request bit is driven by a second, 8-bit enable register, and it also appears as a separate output line. Software reaches every register through one address, one read strobe, one write strobe and a data bus. Command parsing and text handling sit outside the block.

Top module: `stat_reg_block`

Address map: `addr[3:2]` selects the group (0 operation, 1 questionable, 2 standard-event, 3 system). For groups 0 to 2, `addr[1:0]` selects the register: 0 condition, 1 event, 2 enable. For the system group, `addr[1:0]` selects 0 status byte, 1 service-request enable, 2 preset (write only).

## Requirements
- R1: The condition register of a group holds the raw condition vector sampled on the previous clock edge. A read of the condition address returns it.
- R2: An event bit is set on the first edge at which its condition bit is seen at 1 after having been sampled at 0. The event bit stays set after the condition returns to 0. A condition that is held high or that falls sets nothing.
- R3: A read of an event address returns the current event value, and the register is zero after that edge.
- R4: When a condition bit rises in the same cycle as a read of its event register, the read returns the old value and the bit is set afterwards.
- R5: Enable masks reset to zero and can be written and read back. A group summary is 1 exactly when some bit is set in both its event register and its enable mask.
- R6: Status byte layout: bit 7 is the operation summary, bit 6 the service request, bit 5 the standard-event summary, bit 4 `msg_avail`, bit 3 the questionable summary. Bits 2:0 read 0.
- R7: The questionable condition is held at zero internally. Its condition and event registers always read 0, and status byte bit 3 stays 0 whatever its enable mask holds.
- R8: Service request (status byte bit 6 and `srq`) is 1 exactly when the AND of the status byte and the 8-bit service-request enable, with bit 6 excluded, is nonzero. Enable bit 6 has no effect.
- R9: A write to the preset address clears all three enable masks and all event registers. It leaves condition registers and the service-request enable unchanged.
- R10: Writes to condition or event addresses change nothing. Reads of unmapped addresses (any `addr[1:0]`=3, system select 2) return 0.
- R11: After reset every register, `status_byte` and `srq` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oper_cond | input | 16 | Raw operation condition vector |
| std_cond | input | 16 | Raw standard-event condition vector |
| msg_avail | input | 1 | Message-available flag, shown on status byte bit 4 |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe; clears the addressed event register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Contents of the addressed register (combinational) |
| status_byte | output | 8 | Summary status byte |
| srq | output | 1 | Service-request line |

## Verification
The hardest case is a condition rise that lands in the same clock as a read of that group's event register. The read-clear and the new edge then meet at one flop, and only a priority that favours the set keeps the edge. The bench first leaves an older event pending. It then changes the raw condition and raises the read strobe at the same falling edge. It checks that the read shows only the old event and that a second read shows only the new one. The service-request enable bit 6 case is reached in a similar way: the service request is forced high through a real summary before that bit is set alone.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int REG_W   = 16;
  localparam int SB_W    = 8;
  localparam int ADDR_W  = 4;
  localparam int NUM_GRP = 3;

  typedef enum logic [1:0] {
    GRP_OPER = 2'd0,
    GRP_QUES = 2'd1,
    GRP_STD  = 2'd2,
    GRP_SYS  = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    SEL_COND   = 2'd0,
    SEL_EVENT  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } sel_e;

  localparam logic [1:0] SYS_STB    = 2'd0;
  localparam logic [1:0] SYS_SRE    = 2'd1;
  localparam logic [1:0] SYS_PRESET = 2'd2;

  localparam int SB_QUES = 3;
  localparam int SB_MAV  = 4;
  localparam int SB_STD  = 5;
  localparam int SB_RQS  = 6;
  localparam int SB_OPER = 7;
endpackage

// File: rtl/stat_decode.sv
module stat_decode #(
  parameter int NUM_GRP = stat_pkg::NUM_GRP,
  parameter int ADDR_W  = stat_pkg::ADDR_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_en,
  input  logic               wr_en,
  output logic [NUM_GRP-1:0] ev_rd,
  output logic [NUM_GRP-1:0] en_wr,
  output logic               sre_wr,
  output logic               preset
);
  import stat_pkg::*;

  localparam int SEL_W = 2;

  logic [SEL_W-1:0] grp_f;
  logic [SEL_W-1:0] sel_f;

  assign grp_f = addr[ADDR_W-1 -: SEL_W];
  assign sel_f = addr[SEL_W-1:0];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_dec
    always_comb begin
      ev_rd[g] = rd_en && (grp_f == SEL_W'(g)) && (sel_e'(sel_f) == SEL_EVENT);
      en_wr[g] = wr_en && (grp_f == SEL_W'(g)) && (sel_e'(sel_f) == SEL_ENABLE);
    end
  end

  always_comb begin
    sre_wr = wr_en && (grp_e'(grp_f) == GRP_SYS) && (sel_f == SYS_SRE);
    preset = wr_en && (grp_e'(grp_f) == GRP_SYS) && (sel_f == SYS_PRESET);
  end
endmodule

// File: rtl/stat_group.sv
module stat_group #(
  parameter int W = stat_pkg::REG_W
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_raw,
  input  logic         ev_rd,
  input  logic         en_wr,
  input  logic         preset,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cond_q,
  output logic [W-1:0] event_q,
  output logic [W-1:0] enable_q,
  output logic         summary
);
  logic [W-1:0] rise;
  logic [W-1:0] event_d;
  logic [W-1:0] enable_d;
  logic         ev_clr;
  logic         ev_ce;
  logic         en_ce;

  // Next-state logic: a new edge always wins over a clear in the same cycle.
  always_comb begin
    rise     = cond_raw & ~cond_q;
    ev_clr   = ev_rd | preset;
    ev_ce    = ev_clr | (|rise);
    event_d  = (ev_clr ? '0 : event_q) | rise;
    en_ce    = preset | en_wr;
    enable_d = preset ? '0 : wr_data;
    summary  = |(event_q & enable_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q   <= '0;
      event_q  <= '0;
      enable_q <= '0;
    end else begin
      cond_q <= cond_raw;
      if (ev_ce) event_q  <= event_d;
      if (en_ce) enable_q <= enable_d;
    end
  end

  assert_event_sets_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (|rise) |=> ((event_q & $past(rise)) == $past(rise)));

  assert_event_needs_rise_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((event_q & ~$past(event_q) & ~$past(rise)) == '0));

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ev_rd && !(|rise)) |=> (event_q == '0));

  assert_mask_holds_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!preset && !en_wr) |=> $stable(enable_q));

  assert_preset_clears_mask_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    preset |=> (enable_q == '0));
endmodule

// File: rtl/stat_summary_byte.sv
module stat_summary_byte #(
  parameter int NUM_GRP = stat_pkg::NUM_GRP,
  parameter int SB_W    = stat_pkg::SB_W
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_GRP-1:0] grp_sum,
  input  logic               mav,
  input  logic               sre_wr,
  input  logic [SB_W-1:0]    wr_data,
  output logic [SB_W-1:0]    stb,
  output logic [SB_W-1:0]    sre_q,
  output logic               srq
);
  import stat_pkg::*;

  localparam logic [SB_W-1:0] RQS_MASK = SB_W'(1) << SB_RQS;

  logic [SB_W-1:0] stb_base;
  logic            rqs;

  always_comb begin
    stb_base          = '0;
    stb_base[SB_OPER] = grp_sum[GRP_OPER];
    stb_base[SB_STD]  = grp_sum[GRP_STD];
    stb_base[SB_MAV]  = mav;
    stb_base[SB_QUES] = grp_sum[GRP_QUES];
    rqs               = |(stb_base & sre_q & ~RQS_MASK);
    stb               = stb_base | (rqs ? RQS_MASK : '0);
    srq               = stb[SB_RQS];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sre_q <= '0;
    else if (sre_wr) sre_q <= wr_data;
  end

  assert_sre_bit6_inert_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (sre_q == RQS_MASK) |-> !srq);

  assert_sre_zero_quiet_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (sre_q == '0) |-> !stb[SB_RQS]);
endmodule

// File: rtl/stat_reg_block.sv
module stat_reg_block #(
  parameter int W       = stat_pkg::REG_W,
  parameter int SB_W    = stat_pkg::SB_W,
  parameter int ADDR_W  = stat_pkg::ADDR_W,
  parameter int NUM_GRP = stat_pkg::NUM_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      oper_cond,
  input  logic [W-1:0]      std_cond,
  input  logic              msg_avail,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  output logic [SB_W-1:0]   status_byte,
  output logic              srq
);
  import stat_pkg::*;

  localparam int SEL_W = 2;

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic [NUM_GRP-1:0]        ev_rd;
  logic [NUM_GRP-1:0]        en_wr;
  logic                      sre_wr;
  logic                      preset;
  logic [NUM_GRP-1:0][W-1:0] cond_in;
  logic [NUM_GRP-1:0][W-1:0] cond_q;
  logic [NUM_GRP-1:0][W-1:0] event_q;
  logic [NUM_GRP-1:0][W-1:0] enable_q;
  logic [NUM_GRP-1:0]        grp_sum;
  logic [SB_W-1:0]           sre_q;

  stat_decode #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_dec (
    .addr   (addr),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .ev_rd  (ev_rd),
    .en_wr  (en_wr),
    .sre_wr (sre_wr),
    .preset (preset)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    if (g == GRP_OPER) begin : g_src
      assign cond_in[g] = oper_cond;
    end else if (g == GRP_STD) begin : g_src
      assign cond_in[g] = std_cond;
    end else begin : g_src
      assign cond_in[g] = '0;
    end

    stat_group #(.W(W)) u_grp (
      .clk      (clk),
      .rst_ni   (rst_ni),
      .cond_raw (cond_in[g]),
      .ev_rd    (ev_rd[g]),
      .en_wr    (en_wr[g]),
      .preset   (preset),
      .wr_data  (wr_data),
      .cond_q   (cond_q[g]),
      .event_q  (event_q[g]),
      .enable_q (enable_q[g]),
      .summary  (grp_sum[g])
    );
  end

  stat_summary_byte #(.NUM_GRP(NUM_GRP), .SB_W(SB_W)) u_sum (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .grp_sum (grp_sum),
    .mav     (msg_avail),
    .sre_wr  (sre_wr),
    .wr_data (wr_data[SB_W-1:0]),
    .stb     (status_byte),
    .sre_q   (sre_q),
    .srq     (srq)
  );

  logic [SEL_W-1:0] grp_f;
  logic [SEL_W-1:0] sel_f;
  assign grp_f = addr[ADDR_W-1 -: SEL_W];
  assign sel_f = addr[SEL_W-1:0];

  always_comb begin
    rd_data = '0;
    if (grp_e'(grp_f) == GRP_SYS) begin
      if (sel_f == SYS_STB)      rd_data = W'(status_byte);
      else if (sel_f == SYS_SRE) rd_data = W'(sre_q);
    end else if (int'(grp_f) < NUM_GRP) begin
      unique case (sel_e'(sel_f))
        SEL_COND:   rd_data = cond_q[grp_f];
        SEL_EVENT:  rd_data = event_q[grp_f];
        SEL_ENABLE: rd_data = enable_q[grp_f];
        default:    rd_data = '0;
      endcase
    end
  end

  assert_ques_quiet_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !status_byte[SB_QUES]);

  assert_srq_matches_byte_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    srq == status_byte[SB_RQS]);
endmodule

// File: tb/stat_reg_block_test.sv
module stat_reg_block_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] oper_cond;
  logic [15:0] std_cond;
  logic        msg_avail;
  logic [3:0]  addr;
  logic        rd_en;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [7:0]  status_byte;
  logic        srq;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [3:0] A_OP_C = 4'h0, A_OP_E = 4'h1, A_OP_N = 4'h2;
  localparam logic [3:0] A_QU_C = 4'h4, A_QU_E = 4'h5, A_QU_N = 4'h6;
  localparam logic [3:0] A_SE_C = 4'h8, A_SE_E = 4'h9, A_SE_N = 4'hA;
  localparam logic [3:0] A_STB  = 4'hC, A_SRE  = 4'hD, A_PRE  = 4'hE;

  always #2 clk = ~clk;

  stat_reg_block uut (
    .clk(clk), .rst_n(rst_n), .oper_cond(oper_cond), .std_cond(std_cond),
    .msg_avail(msg_avail), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .status_byte(status_byte), .srq(srq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clean();
    oper_cond = '0; std_cond = '0; msg_avail = 1'b0;
    tick();
    wr(A_PRE, 16'h0);
    wr(A_SRE, 16'h0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R11 reset register", d, 16'h0);
    end
    chk("R11 reset status byte", {8'h0, status_byte}, 16'h0);
    chk("R11 reset srq", {15'h0, srq}, 16'h0);
  endtask

  task automatic t_edges();
    logic [15:0] d;
    clean();
    oper_cond = 16'hA5A5; tick();
    rd(A_OP_C, d); chk("R1 condition follows input", d, 16'hA5A5);
    rd(A_OP_E, d); chk("R2 rising bits latch", d, 16'hA5A5);
    rd(A_OP_E, d); chk("R3 read clears event", d, 16'h0);
    tick(); tick();
    rd(A_OP_E, d); chk("R2 held high sets nothing", d, 16'h0);
    oper_cond = 16'h0; tick();
    rd(A_OP_E, d); chk("R2 falling sets nothing", d, 16'h0);
    oper_cond = 16'h0100; tick(); tick(); oper_cond = 16'h0; tick();
    rd(A_OP_E, d); chk("R2 event sticks after fall", d, 16'h0100);
    rd(A_OP_C, d); chk("R1 condition back to zero", d, 16'h0);
  endtask

  task automatic t_concurrent();
    logic [15:0] d;
    clean();
    oper_cond = 16'h0002; tick();
    oper_cond = 16'h8002;
    rd(A_OP_E, d); chk("R4 read returns old event", d, 16'h0002);
    rd(A_OP_E, d); chk("R4 concurrent rise kept", d, 16'h8000);
  endtask

  task automatic t_summary();
    logic [15:0] d;
    clean();
    wr(A_OP_N, 16'h0010);
    rd(A_OP_N, d); chk("R5 enable readback", d, 16'h0010);
    oper_cond = 16'h0001; tick();
    chk("R5 unmasked event no summary", {8'h0, status_byte}, 16'h0);
    oper_cond = 16'h0011; tick();
    chk("R5 masked event summary bit7", {8'h0, status_byte}, 16'h0080);
    rd(A_OP_E, d);
    chk("R5 summary drops after read", {8'h0, status_byte}, 16'h0);
  endtask

  task automatic t_layout();
    clean();
    wr(A_SE_N, 16'hFFFF);
    std_cond = 16'h0004; tick();
    chk("R6 std summary bit5", {8'h0, status_byte}, 16'h0020);
    msg_avail = 1'b1; #1;
    chk("R6 mav bit4", {8'h0, status_byte}, 16'h0030);
  endtask

  task automatic t_ques();
    logic [15:0] d;
    clean();
    wr(A_QU_N, 16'hFFFF);
    rd(A_QU_N, d); chk("R7 ques enable readback", d, 16'hFFFF);
    oper_cond = 16'hFFFF; std_cond = 16'hFFFF; tick();
    rd(A_QU_C, d); chk("R7 ques condition zero", d, 16'h0);
    rd(A_QU_E, d); chk("R7 ques event zero", d, 16'h0);
    chk("R7 status bit3 clear", {15'h0, status_byte[3]}, 16'h0);
  endtask

  task automatic t_sre();
    logic [15:0] d;
    clean();
    wr(A_SE_N, 16'h0001);
    std_cond = 16'h0001; msg_avail = 1'b1; tick();
    wr(A_SRE, 16'h0010);
    chk("R8 srq from mav", {15'h0, srq}, 16'h1);
    chk("R8 status byte with rqs", {8'h0, status_byte}, 16'h0070);
    wr(A_SRE, 16'h0040);
    chk("R8 sre bit6 has no effect", {15'h0, srq}, 16'h0);
    rd(A_SRE, d); chk("R8 sre readback", d, 16'h0040);
    wr(A_SRE, 16'h0010);
    msg_avail = 1'b0; #1;
    chk("R8 srq drops with source", {15'h0, srq}, 16'h0);
  endtask

  task automatic t_preset();
    logic [15:0] d;
    clean();
    wr(A_OP_N, 16'h1234); wr(A_SE_N, 16'h00FF); wr(A_SRE, 16'h0080);
    oper_cond = 16'h0F00; std_cond = 16'h0003; tick();
    wr(A_PRE, 16'h0);
    rd(A_OP_N, d); chk("R9 oper enable cleared", d, 16'h0);
    rd(A_SE_N, d); chk("R9 std enable cleared", d, 16'h0);
    rd(A_OP_E, d); chk("R9 oper event cleared", d, 16'h0);
    rd(A_SE_E, d); chk("R9 std event cleared", d, 16'h0);
    rd(A_OP_C, d); chk("R9 condition kept", d, 16'h0F00);
    rd(A_SRE, d);  chk("R9 sre kept", d, 16'h0080);
  endtask

  task automatic t_map();
    logic [15:0] d;
    clean();
    oper_cond = 16'h0050; tick();
    wr(A_OP_C, 16'hFFFF);
    wr(A_OP_E, 16'h0000);
    rd(A_OP_C, d); chk("R10 condition write ignored", d, 16'h0050);
    rd(A_OP_E, d); chk("R10 event write ignored", d, 16'h0050);
    rd(4'h3, d); chk("R10 unmapped oper slot", d, 16'h0);
    rd(4'hE, d); chk("R10 preset reads zero", d, 16'h0);
    rd(4'hF, d); chk("R10 unmapped sys slot", d, 16'h0);
  endtask

  initial begin
    rst_n = 1'b0; oper_cond = '0; std_cond = '0; msg_avail = 1'b0;
    addr = '0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_edges();
    t_concurrent();
    t_summary();
    t_layout();
    t_ques();
    t_sre();
    t_preset();
    t_map();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule